// File: doc/BRIEF.md
# Four-Slot Page Translation Buffer

This block turns a 32-bit virtual address into a physical address for the process that is currently running. It holds four fully associative slots. Each slot has a tag word and a physical-page word. The tag word carries three things: the virtual page in its upper bits, the owning process number shifted up by one bit, and a write-permission flag in bit 0. Pages are 4 KB. The low twelve bits of the virtual address are ORed into the physical page word of the chosen slot. Software fills the slots through a small register window, and it alone decides which slot to overwrite. The current process number lives in a register of the same window.

A lookup arrives on a valid/ready request channel, and the answer comes back on the response channel in the same cycle. Translation is skipped when the process number is zero or when the request is not from user mode. In that case the virtual address comes back unchanged. When no slot matches, the response reports a miss. If that miss is accepted, the block stores the faulting page and raises a fault interrupt. Any write into the slot window clears the interrupt.

Back-pressure follows these rules:
- The response is valid whenever the request is valid.
- The request is ready exactly when the response side is ready.
- A lookup counts as done only in a cycle where both valid and ready are high, and only then can it change the fault state.
- A requester that is stalled must hold its inputs stable.

Top module: `tlb_xlate`

## Requirements
- R1: When the process register holds 0, or `lk_user` is 0, the response gives `rs_paddr` equal to `lk_vaddr` and `rs_miss` = 0.
- R2: A slot matches when tag bits [31:1] equal bits [31:1] of ({vaddr[31:12], 12'b0} | (pid << 1)). On a match, `rs_paddr` = physical word | vaddr[11:0], and `rs_miss` = 0.
- R3: Tag bit 0 is the write permission. A lookup with `lk_write` = 1 matches only slots whose bit 0 is 1. Read lookups ignore bit 0.
- R4: When more than one slot matches, the slot with the lowest index supplies the translation.
- R5: When translation is active and no slot matches, `rs_miss` = 1 and `rs_paddr` = `lk_vaddr`.
- R6: On a miss that is accepted (`lk_valid` and `rs_ready` both high), the next cycle shows the fault address register = vaddr with bits [11:0] cleared, and `fault_irq` = 1. A miss that is not accepted changes neither.
- R7: The slot window starts at 0x200000A0. Slot i has its tag at 0x200000A0 + 8*i and its physical word at 0x200000A4 + 8*i. A write is used by lookups from the next cycle on.
- R8: Any write to an address in 0x200000A0..0x200000BF clears `fault_irq` in the next cycle. An accepted miss in the same cycle takes priority, and the interrupt stays set.
- R9: Writing 0x20000080 loads the process register from `cfg_wdata[7:0]`, and reading it returns that value zero-extended. Reading 0x20000090 returns the fault address, and writes to 0x20000090 are ignored. All other addresses read 0.
- R10: A synchronous reset clears every tag and physical word, the process register, the fault address and `fault_irq`.
- R11: `rs_valid` follows `lk_valid`, and `lk_ready` follows `rs_ready`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a store |
| lk_user | input | 1 | Access comes from user mode |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response consumer ready |
| rs_paddr | output | 32 | Physical address, or the virtual address on bypass or miss |
| rs_miss | output | 1 | No slot matched while translation was active |
| cfg_wr | input | 1 | Register window write strobe |
| cfg_addr | input | 32 | Register window address |
| cfg_wdata | input | 32 | Register window write data |
| cfg_rdata | output | 32 | Register window read data, combinational |
| fault_irq | output | 1 | Pending translation-fault interrupt |

## Verification
The slots are loaded so that two of them share a page: one is writable and one is read-only, which separates the priority rule from the permission rule. A third slot is read-only on its own page, and a fourth belongs to a different process. Reads and stores are then sent across these pages under several process numbers and both privilege levels. This tells a real translation apart from a bypass, a process mismatch and a permission miss, and each outcome leaves its own fault address behind. Two cases isolate the interrupt bookkeeping: a miss stalled by back-pressure, and a miss that lands in the same cycle as a slot write. A reset in the middle of the run shows that the slots were cleared.

// File: rtl/tlb_xlate_pkg.sv
`timescale 1ns/1ps
package tlb_xlate_pkg;
  typedef logic [31:0] word_t;
  localparam word_t PID_REG_ADDR   = 32'h2000_0080;
  localparam word_t FAULT_REG_ADDR = 32'h2000_0090;
  localparam word_t WINDOW_BASE    = 32'h2000_00A0;
endpackage

// File: rtl/tlb_entry_regs.sv
`timescale 1ns/1ps
module tlb_entry_regs
  import tlb_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_wr,
  input  word_t                       cfg_addr,
  input  word_t                       cfg_wdata,
  output logic [NUM_ENTRIES-1:0][31:0] tag_q,
  output logic [NUM_ENTRIES-1:0][31:0] phys_q,
  output logic                        window_wr
);
  localparam int IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int SPAN    = NUM_ENTRIES * 8;

  word_t offset;
  logic  in_window;

  assign offset    = cfg_addr - WINDOW_BASE;
  assign in_window = (cfg_addr >= WINDOW_BASE) && (offset < word_t'(SPAN));
  assign window_wr = cfg_wr && in_window;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic slot_sel;
    assign slot_sel = window_wr && (offset[IDX_W+2:3] == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[i]  <= '0;
        phys_q[i] <= '0;
      end else if (slot_sel) begin
        if (offset[2]) phys_q[i] <= cfg_wdata;
        else           tag_q[i]  <= cfg_wdata;
      end
    end
  end

  // R7: slot 0 tag write lands on the next cycle
  assert_slot0_tag_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == WINDOW_BASE) |=> (tag_q[0] == $past(cfg_wdata)));

  // R10: reset leaves every tag cleared
  assert_tags_cleared_R10: assert property (@(posedge clk)
    $past(rst) |-> (tag_q == '0));
endmodule

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
  import tlb_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int PAGE_BITS   = 12,
  parameter int PID_BITS    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_ENTRIES-1:0][31:0] tag_q,
  input  logic [NUM_ENTRIES-1:0][31:0] phys_q,
  input  word_t                        vaddr,
  input  logic [PID_BITS-1:0]          pid,
  input  logic                         is_write,
  output logic                         hit,
  output word_t                        paddr
);
  localparam word_t PAGE_MASK = ~((word_t'(1) << PAGE_BITS) - word_t'(1));

  word_t                  cmp;
  logic [NUM_ENTRIES-1:0] cand;
  logic [NUM_ENTRIES-1:0] sel;
  word_t                  page;

  assign cmp = (vaddr & PAGE_MASK) | (word_t'(pid) << 1);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    assign cand[i] = (tag_q[i][31:1] == cmp[31:1]) && (!is_write || tag_q[i][0]);
  end

  always_comb begin
    sel  = '0;
    hit  = 1'b0;
    page = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (cand[i] && !hit) begin
        sel[i] = 1'b1;
        hit    = 1'b1;
        page   = phys_q[i];
      end
    end
  end

  assign paddr = page | (vaddr & ~PAGE_MASK);

  // R4: at most one slot is picked
  assert_single_pick_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  for (genvar i = 1; i < NUM_ENTRIES; i++) begin : g_prio_chk
    // R4: a picked slot has no lower-numbered candidate
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
      sel[i] |-> (cand[i-1:0] == '0));
  end
endmodule

// File: rtl/tlb_fault_ctl.sv
`timescale 1ns/1ps
module tlb_fault_ctl
  import tlb_xlate_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  take_miss,
  input  word_t miss_vaddr,
  input  logic  clear_req,
  output word_t fault_addr,
  output logic  irq
);
  localparam word_t PAGE_MASK = ~((word_t'(1) << PAGE_BITS) - word_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr <= '0;
      irq        <= 1'b0;
    end else if (take_miss) begin
      fault_addr <= miss_vaddr & PAGE_MASK;
      irq        <= 1'b1;
    end else if (clear_req) begin
      irq <= 1'b0;
    end
  end

  // R6: accepted miss raises the interrupt with the page recorded
  assert_miss_capture_R6: assert property (@(posedge clk) disable iff (rst)
    take_miss |=> (irq && fault_addr[PAGE_BITS-1:0] == '0 &&
                   fault_addr[31:PAGE_BITS] == $past(miss_vaddr[31:PAGE_BITS])));

  // R8: window write without a miss clears the interrupt
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clear_req && !take_miss) |=> !irq);

  // R6: without an accepted miss the fault address holds
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !take_miss |=> $stable(fault_addr));
endmodule

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int PAGE_BITS   = 12,
  parameter int PID_BITS    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_write,
  input  logic        lk_user,
  output logic        rs_valid,
  input  logic        rs_ready,
  output logic [31:0] rs_paddr,
  output logic        rs_miss,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        fault_irq
);
  logic [NUM_ENTRIES-1:0][31:0] tag_q;
  logic [NUM_ENTRIES-1:0][31:0] phys_q;
  logic                         window_wr;
  logic [PID_BITS-1:0]          pid_q;
  logic                         m_hit;
  word_t                        m_paddr;
  logic                         bypass;
  logic                         take_miss;
  word_t                        fault_addr;

  tlb_entry_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tag_q(tag_q), .phys_q(phys_q),
    .window_wr(window_wr)
  );

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES), .PAGE_BITS(PAGE_BITS),
              .PID_BITS(PID_BITS)) u_match (
    .clk(clk), .rst(rst), .tag_q(tag_q), .phys_q(phys_q),
    .vaddr(lk_vaddr), .pid(pid_q), .is_write(lk_write),
    .hit(m_hit), .paddr(m_paddr)
  );

  tlb_fault_ctl #(.PAGE_BITS(PAGE_BITS)) u_fault (
    .clk(clk), .rst(rst), .take_miss(take_miss), .miss_vaddr(lk_vaddr),
    .clear_req(window_wr), .fault_addr(fault_addr), .irq(fault_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  pid_q <= '0;
    else if (cfg_wr && cfg_addr == PID_REG_ADDR) pid_q <= cfg_wdata[PID_BITS-1:0];
  end

  assign bypass    = (pid_q == '0) || !lk_user;
  assign rs_miss   = !bypass && !m_hit;
  assign rs_paddr  = (bypass || !m_hit) ? lk_vaddr : m_paddr;
  assign rs_valid  = lk_valid;
  assign lk_ready  = rs_ready;
  assign take_miss = lk_valid && rs_ready && rs_miss;

  always_comb begin
    if (cfg_addr == PID_REG_ADDR)        cfg_rdata = word_t'(pid_q);
    else if (cfg_addr == FAULT_REG_ADDR) cfg_rdata = fault_addr;
    else                                 cfg_rdata = '0;
  end

  // R1: bypass returns the virtual address without a miss
  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !lk_user) |-> (!rs_miss && rs_paddr == lk_vaddr));

  // R2: a translated address keeps the page offset bits
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_miss) |->
      ((rs_paddr[PAGE_BITS-1:0] & lk_vaddr[PAGE_BITS-1:0]) == lk_vaddr[PAGE_BITS-1:0]));

  // R5: a miss returns the virtual address
  assert_miss_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_miss) |-> (rs_paddr == lk_vaddr));
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  localparam logic [31:0] PID_A   = 32'h2000_0080;
  localparam logic [31:0] FAULT_A = 32'h2000_0090;
  localparam logic [31:0] WIN_A   = 32'h2000_00A0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        rs_ready = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_addr = '0, cfg_wdata = '0;
  logic        lk_ready, rs_valid, rs_miss, fault_irq;
  logic [31:0] rs_paddr, cfg_rdata;

  always #5 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_paddr(rs_paddr),
    .rs_miss(rs_miss), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fault_irq(fault_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [32:0] exp_q[$];
  string       req_q[$];
  logic [32:0] mon_e;
  string       mon_r;
  bit          done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // scoreboard monitor: compares every accepted response
  always @(negedge clk) begin
    if (!rst && lk_valid && rs_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11 actual=unexpected response expected=none");
      end else begin
        mon_e = exp_q.pop_front();
        mon_r = req_q.pop_front();
        chk(mon_r, {31'b0, rs_miss}, {31'b0, mon_e[32]});
        chk(mon_r, rs_paddr, mon_e[31:0]);
      end
    end
  end

  task automatic lookup(string req, logic [31:0] va, logic wr, logic user,
                        logic [31:0] exp_pa, logic exp_miss);
    exp_q.push_back({exp_miss, exp_pa});
    req_q.push_back(req);
    lk_vaddr = va; lk_write = wr; lk_user = user; lk_valid = 1'b1;
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic cfg_write(logic [31:0] a, logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(string req, logic [31:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10", {31'b0, fault_irq}, 32'd0);
    cfg_read("R10", PID_A, 32'h0);
    cfg_read("R10", FAULT_A, 32'h0);

    cfg_write(PID_A, 32'd5);
    cfg_read("R9", PID_A, 32'd5);
    // R10: cleared slots, so a user lookup with pid 5 misses
    lookup("R10", 32'h0040_0ABC, 1'b0, 1'b1, 32'h0040_0ABC, 1'b1);
    chk("R6", {31'b0, fault_irq}, 32'd1);
    cfg_read("R6", FAULT_A, 32'h0040_0000);

    // R7: load slots; first window write clears the interrupt (R8)
    cfg_write(WIN_A + 32'h00, 32'h0040_000B);
    chk("R8", {31'b0, fault_irq}, 32'd0);
    cfg_write(WIN_A + 32'h04, 32'h1000_1000);
    cfg_write(WIN_A + 32'h08, 32'h0080_000A);
    cfg_write(WIN_A + 32'h0C, 32'h1000_2000);
    cfg_write(WIN_A + 32'h10, 32'h0040_000A);
    cfg_write(WIN_A + 32'h14, 32'h1000_3000);
    cfg_write(WIN_A + 32'h18, 32'h00C0_000F);
    cfg_write(WIN_A + 32'h1C, 32'h1000_4000);

    // R2 / R4: slot 0 beats slot 2 on the shared page
    lookup("R4", 32'h0040_0ABC, 1'b0, 1'b1, 32'h1000_1ABC, 1'b0);
    // R3: store on writable slot
    lookup("R3", 32'h0040_0010, 1'b1, 1'b1, 32'h1000_1010, 1'b0);
    // R3: read of read-only slot ignores bit 0
    lookup("R3", 32'h0080_0004, 1'b0, 1'b1, 32'h1000_2004, 1'b0);
    // R3 / R5: store to read-only page misses
    lookup("R5", 32'h0080_0004, 1'b1, 1'b1, 32'h0080_0004, 1'b1);
    chk("R6", {31'b0, fault_irq}, 32'd1);
    cfg_read("R6", FAULT_A, 32'h0080_0000);
    cfg_write(WIN_A + 32'h1C, 32'h1000_4000);
    chk("R8", {31'b0, fault_irq}, 32'd0);

    // R5: process mismatch
    lookup("R5", 32'h00C0_0100, 1'b0, 1'b1, 32'h00C0_0100, 1'b1);
    cfg_read("R6", FAULT_A, 32'h00C0_0000);
    // R9: fault register is read-only, unmapped reads zero, pid width
    cfg_write(FAULT_A, 32'hDEAD_0000);
    cfg_read("R9", FAULT_A, 32'h00C0_0000);
    cfg_read("R9", 32'h2000_0040, 32'h0);
    cfg_write(PID_A, 32'h1234_5607);
    cfg_read("R9", PID_A, 32'h0000_0007);

    // R2: pid 7 now hits slot 3
    lookup("R2", 32'h00C0_0100, 1'b0, 1'b1, 32'h1000_4100, 1'b0);
    // R1: kernel mode bypass
    lookup("R1", 32'h00C0_0100, 1'b0, 1'b0, 32'h00C0_0100, 1'b0);
    // R7: retag slot 1 for pid 7, writable
    cfg_write(WIN_A + 32'h08, 32'h0080_000F);
    lookup("R7", 32'h0080_0444, 1'b1, 1'b1, 32'h1000_2444, 1'b0);
    chk("R8", {31'b0, fault_irq}, 32'd0);

    // R11 / R6: stalled miss has no effect
    rs_ready = 1'b0;
    lk_vaddr = 32'h00F0_0000; lk_write = 1'b0; lk_user = 1'b1; lk_valid = 1'b1;
    #1;
    chk("R11", {30'b0, lk_ready, rs_valid}, 32'd1);
    chk("R11", {31'b0, rs_miss}, 32'd1);
    @(posedge clk); #1;
    lk_valid = 1'b0; rs_ready = 1'b1;
    chk("R6", {31'b0, fault_irq}, 32'd0);
    cfg_read("R6", FAULT_A, 32'h00C0_0000);

    // R8: accepted miss and window write in the same cycle
    exp_q.push_back({1'b1, 32'h00E0_0123});
    req_q.push_back("R8");
    lk_vaddr = 32'h00E0_0123; lk_write = 1'b0; lk_user = 1'b1; lk_valid = 1'b1;
    cfg_wr = 1'b1; cfg_addr = WIN_A + 32'h14; cfg_wdata = 32'h1000_3000;
    @(posedge clk); #1;
    lk_valid = 1'b0; cfg_wr = 1'b0;
    chk("R8", {31'b0, fault_irq}, 32'd1);
    cfg_read("R8", FAULT_A, 32'h00E0_0000);

    // R1: process 0 bypass in user mode
    cfg_write(PID_A, 32'd0);
    lookup("R1", 32'h0040_0ABC, 1'b0, 1'b1, 32'h0040_0ABC, 1'b0);

    // R10: reset in mid run clears slots and registers
    do_reset();
    chk("R10", {31'b0, fault_irq}, 32'd0);
    cfg_read("R10", FAULT_A, 32'h0);
    cfg_read("R10", PID_A, 32'h0);
    cfg_write(PID_A, 32'd5);
    lookup("R10", 32'h0040_0ABC, 1'b0, 1'b1, 32'h0040_0ABC, 1'b1);

    @(posedge clk); #1;
    chk("R11", exp_q.size(), 32'd0);
    done = 1'b1;
    summary();
  end
endmodule